// File: doc/BRIEF.md
# Paired-Page TLB Address Translator

This block translates 32-bit virtual addresses for a software-managed processor through a small fully associative table. Each table entry holds a tag for a pair of adjacent virtual pages, an address-space identifier and one global flag. It also holds two physical frame descriptors, one for the even page of the pair and one for the odd page. Each descriptor carries its own valid, dirty and three-bit cache attribute. Software fills entries through an indexed write port and reads them back through an indexed read port in the packed low-word format.

Instruction fetch and data accesses share a single lookup port. Each lookup yields either a physical address or exactly one fault class. A faulting lookup also yields the values that the exception logic loads into its fault registers. The two unmapped kernel windows at 0x8000_0000 and 0xA000_0000 skip the table: their physical address is the virtual address with the top three bits cleared. The cached window is open only in kernel mode. A lookup resolves combinationally, and its result is registered and appears one cycle later.

Top module: `pair_tlb`

## Requirements
- R1: A lookup presented with `lkValid` high on a clock edge produces `rspValid` high after that edge, with its result on the response outputs. A cycle without `lkValid` gives `rspValid` low after the edge. Reset clears every response output to zero.
- R2: Writing index i stores `wrVpn`, `wrAsid` and both low words. Each low word is packed as PFN in bits [PFN_W+5:6], C in [5:3], D in bit 2, V in bit 1 and G in bit 0. The shared global flag becomes the AND of the two written G bits. `rdLo0`/`rdLo1` return the stored even and odd words for `rdIdx` in the same packing, with the shared G in bit 0 of both. Reset clears all entries, so every read returns zero.
- R3: The request tag is `lkVaddr[31:11]`. With `smallPages` low, its two low bits are ignored in the compare on both sides; with `smallPages` high, all 21 bits are compared. An entry matches when the tags agree and either its global flag is set or `lkAsid` equals the stored ASID. An entry whose two valid bits are both clear never matches.
- R4: The half selector is `lkVaddr[12]`, or `lkVaddr[10]` with `smallPages` high. The value 0 picks the even word and 1 picks the odd word.
- R5: With no matching entry the result is a refill fault: code 2 for instruction lookups (`lkIsData`=0) and code 4 for data. A match on a half whose V is 0 gives an invalid fault: code 3 for instruction and code 5 for data.
- R6: A data write (`lkIsData`=1, `lkIsWrite`=1) to a valid half whose D is 0 gives the modified fault, code 6. Data reads and instruction lookups ignore D.
- R7: A successful mapped lookup (code 0) returns `(PFN << 12) | (lkVaddr & 0xFFF)`, or `(PFN << 12) | (lkVaddr & 0x3FF)` with `smallPages` high. Every fault returns a physical address of 0.
- R8: For codes 2 to 6, `rspBadVaddr` is the virtual address, `rspAsid` is `lkAsid`, and `rspVpn2` and `rspCtxVpn2` are `lkVaddr[31:13]`. `rspVpn2x` is `lkVaddr[12:11]`.
- R9: Virtual addresses with bits [31:29] equal to 100 or 101 bypass the table with code 0 and physical address `lkVaddr & 0x1FFF_FFFF`. In the 101 window this holds in every mode, even with `lkMisaligned` set.
- R10: An address error, code 1, arises in two cases: a 100-window access outside kernel mode or with `lkMisaligned` high, and a misaligned access to a mapped address. It takes precedence over any table outcome. `rspBadVaddr` holds the address, and the ASID and VPN fields read 0.
- R11: Kernel mode is active when any of `status` bits 28, 2 or 1 is set, or when `status[4:3]` is 0. The values 1 (supervisor), 2 (user) and 3 are not kernel.
- R12: When several entries match, the one with the lowest index supplies the result.
- R13: A lookup in the same cycle as a write to an entry sees the entry's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write the entry at `wrIdx` |
| wrIdx | input | IDX_W | Entry index for write |
| wrVpn | input | 21 | Tag to store (virtual address bits [31:11]) |
| wrAsid | input | ASID_W | ASID to store |
| wrLo0 | input | PFN_W+6 | Even-page low word, packed |
| wrLo1 | input | PFN_W+6 | Odd-page low word, packed |
| rdIdx | input | IDX_W | Entry index for read |
| rdLo0 | output | PFN_W+6 | Stored even-page low word |
| rdLo1 | output | PFN_W+6 | Stored odd-page low word |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 32 | Virtual address |
| lkAsid | input | ASID_W | Request ASID |
| lkIsData | input | 1 | 1 for data access, 0 for instruction fetch |
| lkIsWrite | input | 1 | Data access is a store |
| lkMisaligned | input | 1 | Access is misaligned for its size |
| smallPages | input | 1 | 1 KiB page mode |
| status | input | 32 | Processor status word for mode decode |
| rspValid | output | 1 | Response present |
| rspCode | output | 3 | 0 ok, 1 address error, 2/3 instr refill/invalid, 4/5 data refill/invalid, 6 modified |
| rspPaddr | output | 32 | Physical address, 0 on fault |
| rspBadVaddr | output | 32 | Faulting virtual address |
| rspAsid | output | ASID_W | Faulting ASID |
| rspVpn2 | output | 19 | Faulting page-pair number |
| rspVpn2x | output | 2 | Low two tag bits of the faulting address |
| rspCtxVpn2 | output | 19 | Page-pair number for the context register |

## Verification
The bench targets these corner cases:
- A lookup issued in the same cycle as a write. A design that let the new data through would hit where a refill is expected.
- An entry whose two halves are both invalid, written to a tag that a higher entry also holds. A design that let empty entries match would report an invalid fault instead of the higher entry's translation.
- Tags that differ only in the two low bits. These must match in normal mode and miss in small-page mode. A design with the mask reversed would report a refill where a hit is expected, or the other way round.
- Stores to clean pages, the kernel-window mode decode with each status field value, and misaligned accesses to each region. These catch a wrong fault priority or a mode mis-decode as a wrong fault code or a leaked physical address.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ADDR     = 3'd1,
    FLT_I_REFILL = 3'd2,
    FLT_I_INVAL  = 3'd3,
    FLT_D_REFILL = 3'd4,
    FLT_D_INVAL  = 3'd5,
    FLT_MOD      = 3'd6
  } fault_e;

  // Strobes from the control decode to the response registers
  typedef struct packed {
    logic   take;      // a lookup is being accepted
    logic   loadPa;    // a physical address is produced
    logic   passThru;  // use the unmapped-window address
    logic   tlbInfo;   // load ASID / page-pair fault fields
    fault_e code;
  } strobe_t;

  localparam int VA_W  = 32;
  localparam int TAG_W = 21;   // virtual address bits [31:11]

endpackage

// File: rtl/pair_tlb_path.sv
module pair_tlb_path
  import pair_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LO_W   = PFN_W + 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [TAG_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [LO_W-1:0]   wrLo0,
  input  logic [LO_W-1:0]   wrLo1,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [LO_W-1:0]   rdLo0,
  output logic [LO_W-1:0]   rdLo1,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  input  logic              smallPages,
  output logic              hit,
  output logic              halfValid,
  output logic              halfDirty,
  output logic [VA_W-1:0]   mappedPa,
  output logic [VA_W-1:0]   segPa
);

  logic [TAG_W-1:0]  eVpn  [ENTRIES];
  logic [ASID_W-1:0] eAsid [ENTRIES];
  logic              eG    [ENTRIES];
  logic [PFN_W-1:0]  ePfn  [ENTRIES][2];
  logic [2:0]        eC    [ENTRIES][2];
  logic              eD    [ENTRIES][2];
  logic              eV    [ENTRIES][2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        eVpn[i]  <= '0;
        eAsid[i] <= '0;
        eG[i]    <= 1'b0;
        for (int h = 0; h < 2; h++) begin
          ePfn[i][h] <= '0;
          eC[i][h]   <= '0;
          eD[i][h]   <= 1'b0;
          eV[i][h]   <= 1'b0;
        end
      end
    end else if (wrEn) begin
      eVpn[wrIdx]    <= wrVpn;
      eAsid[wrIdx]   <= wrAsid;
      eG[wrIdx]      <= wrLo0[0] & wrLo1[0];
      ePfn[wrIdx][0] <= wrLo0[LO_W-1:6];
      ePfn[wrIdx][1] <= wrLo1[LO_W-1:6];
      eC[wrIdx][0]   <= wrLo0[5:3];
      eC[wrIdx][1]   <= wrLo1[5:3];
      eD[wrIdx][0]   <= wrLo0[2];
      eD[wrIdx][1]   <= wrLo1[2];
      eV[wrIdx][0]   <= wrLo0[1];
      eV[wrIdx][1]   <= wrLo1[1];
    end
  end

  assign rdLo0 = {ePfn[rdIdx][0], eC[rdIdx][0], eD[rdIdx][0], eV[rdIdx][0], eG[rdIdx]};
  assign rdLo1 = {ePfn[rdIdx][1], eC[rdIdx][1], eD[rdIdx][1], eV[rdIdx][1], eG[rdIdx]};

  logic [TAG_W-1:0] reqTag, tagMask;
  logic [ENTRIES-1:0] match;
  assign reqTag  = va[VA_W-1:11];
  assign tagMask = smallPages ? '1 : {{(TAG_W-2){1'b1}}, 2'b00};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = (eV[i][0] | eV[i][1])
                    && ((reqTag & tagMask) == (eVpn[i] & tagMask))
                    && (eG[i] || (asid == eAsid[i]));
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
    end
  end

  logic oddHalf;
  logic [VA_W-1:0] offMask;
  assign oddHalf   = smallPages ? va[10] : va[12];
  assign offMask   = smallPages ? 32'h0000_03FF : 32'h0000_0FFF;
  assign hit       = |match;
  assign halfValid = eV[sel][oddHalf];
  assign halfDirty = eD[sel][oddHalf];
  assign mappedPa  = (VA_W'(ePfn[sel][oddHalf]) << 12) | (va & offMask);
  assign segPa     = {3'b000, va[VA_W-4:0]};

endmodule

// File: rtl/pair_tlb_ctrl.sv
module pair_tlb_ctrl
  import pair_tlb_pkg::*;
(
  input  logic        lkValid,
  input  logic [2:0]  vaTop,
  input  logic        isData,
  input  logic        isWrite,
  input  logic        misaligned,
  input  logic [31:0] status,
  input  logic        hit,
  input  logic        halfValid,
  input  logic        halfDirty,
  output strobe_t     st
);

  logic kernelMode, inCached, inUncached;
  assign kernelMode = status[28] | status[2] | status[1] | (status[4:3] == 2'b00);
  assign inCached   = (vaTop == 3'b100);
  assign inUncached = (vaTop == 3'b101);

  always_comb begin
    st      = '0;
    st.take = lkValid;
    if (inUncached) begin
      st.loadPa   = 1'b1;
      st.passThru = 1'b1;
    end else if (inCached) begin
      if (!kernelMode || misaligned) begin
        st.code = FLT_ADDR;
      end else begin
        st.loadPa   = 1'b1;
        st.passThru = 1'b1;
      end
    end else if (misaligned) begin
      st.code = FLT_ADDR;
    end else if (!hit) begin
      st.code    = isData ? FLT_D_REFILL : FLT_I_REFILL;
      st.tlbInfo = 1'b1;
    end else if (!halfValid) begin
      st.code    = isData ? FLT_D_INVAL : FLT_I_INVAL;
      st.tlbInfo = 1'b1;
    end else if (isData && isWrite && !halfDirty) begin
      st.code    = FLT_MOD;
      st.tlbInfo = 1'b1;
    end else begin
      st.loadPa = 1'b1;
    end
  end

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LO_W   = PFN_W + 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [20:0]       wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [LO_W-1:0]   wrLo0,
  input  logic [LO_W-1:0]   wrLo1,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [LO_W-1:0]   rdLo0,
  output logic [LO_W-1:0]   rdLo1,
  input  logic              lkValid,
  input  logic [31:0]       lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkIsData,
  input  logic              lkIsWrite,
  input  logic              lkMisaligned,
  input  logic              smallPages,
  input  logic [31:0]       status,
  output logic              rspValid,
  output logic [2:0]        rspCode,
  output logic [31:0]       rspPaddr,
  output logic [31:0]       rspBadVaddr,
  output logic [ASID_W-1:0] rspAsid,
  output logic [18:0]       rspVpn2,
  output logic [1:0]        rspVpn2x,
  output logic [18:0]       rspCtxVpn2
);

  logic hit, halfValid, halfDirty;
  logic [31:0] mappedPa, segPa;
  strobe_t st;

  pair_tlb_path #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_path (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn), .wrAsid(wrAsid),
    .wrLo0(wrLo0), .wrLo1(wrLo1),
    .rdIdx(rdIdx), .rdLo0(rdLo0), .rdLo1(rdLo1),
    .va(lkVaddr), .asid(lkAsid), .smallPages(smallPages),
    .hit(hit), .halfValid(halfValid), .halfDirty(halfDirty),
    .mappedPa(mappedPa), .segPa(segPa)
  );

  pair_tlb_ctrl u_ctrl (
    .lkValid(lkValid), .vaTop(lkVaddr[31:29]), .isData(lkIsData),
    .isWrite(lkIsWrite), .misaligned(lkMisaligned), .status(status),
    .hit(hit), .halfValid(halfValid), .halfDirty(halfDirty), .st(st)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspCode     <= '0;
      rspPaddr    <= '0;
      rspBadVaddr <= '0;
      rspAsid     <= '0;
      rspVpn2     <= '0;
      rspVpn2x    <= '0;
      rspCtxVpn2  <= '0;
    end else begin
      rspValid <= st.take;
      if (st.take) begin
        rspCode     <= st.code;
        rspPaddr    <= st.loadPa ? (st.passThru ? segPa : mappedPa) : '0;
        rspBadVaddr <= (st.code != FLT_NONE) ? lkVaddr : '0;
        rspAsid     <= st.tlbInfo ? lkAsid : '0;
        rspVpn2     <= st.tlbInfo ? lkVaddr[31:13] : '0;
        rspVpn2x    <= st.tlbInfo ? lkVaddr[12:11] : '0;
        rspCtxVpn2  <= st.tlbInfo ? lkVaddr[31:13] : '0;
      end
    end
  end

endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk (
  input logic        clk,
  input logic        rstN,
  input logic        lkValid,
  input logic [31:0] lkVaddr,
  input logic [31:0] status,
  input logic        rspValid,
  input logic [2:0]  rspCode,
  input logic [31:0] rspPaddr,
  input logic [31:0] rspBadVaddr
);

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);

  a_r1_idle: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);

  a_r7_fault_no_pa: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode != 3'd0) |-> (rspPaddr == 32'd0));

  a_r9_uncached_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkVaddr[31:29] == 3'b101)
      |=> (rspCode == 3'd0 && rspPaddr == {3'b000, $past(lkVaddr[28:0])}));

  a_r10_user_cached_window: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkVaddr[31:29] == 3'b100 && status[4:3] == 2'b10
       && !status[28] && !status[2] && !status[1])
      |=> (rspCode == 3'd1));

  a_r8_bad_vaddr: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (rspCode == 3'd0 || rspBadVaddr == $past(lkVaddr)));

endmodule

bind pair_tlb pair_tlb_chk u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr),
  .status(status), .rspValid(rspValid), .rspCode(rspCode),
  .rspPaddr(rspPaddr), .rspBadVaddr(rspBadVaddr)
);

// File: tb/test_pair_tlb.sv
module test_pair_tlb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [20:0] wrVpn = '0;
  logic [7:0]  wrAsid = '0;
  logic [25:0] wrLo0 = '0, wrLo1 = '0;
  logic [2:0]  rdIdx = '0;
  logic [25:0] rdLo0, rdLo1;
  logic        lkValid = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic [7:0]  lkAsid = '0;
  logic        lkIsData = 1'b0, lkIsWrite = 1'b0, lkMisaligned = 1'b0;
  logic        smallPages = 1'b0;
  logic [31:0] status = '0;
  logic        rspValid;
  logic [2:0]  rspCode;
  logic [31:0] rspPaddr, rspBadVaddr;
  logic [7:0]  rspAsid;
  logic [18:0] rspVpn2, rspCtxVpn2;
  logic [1:0]  rspVpn2x;

  always #5 clk = ~clk;

  pair_tlb i_pair_tlb (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn),
    .wrAsid(wrAsid), .wrLo0(wrLo0), .wrLo1(wrLo1), .rdIdx(rdIdx),
    .rdLo0(rdLo0), .rdLo1(rdLo1), .lkValid(lkValid), .lkVaddr(lkVaddr),
    .lkAsid(lkAsid), .lkIsData(lkIsData), .lkIsWrite(lkIsWrite),
    .lkMisaligned(lkMisaligned), .smallPages(smallPages), .status(status),
    .rspValid(rspValid), .rspCode(rspCode), .rspPaddr(rspPaddr),
    .rspBadVaddr(rspBadVaddr), .rspAsid(rspAsid), .rspVpn2(rspVpn2),
    .rspVpn2x(rspVpn2x), .rspCtxVpn2(rspCtxVpn2)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Reference model state
  logic [20:0] mVpn [8];
  logic [7:0]  mAsid [8];
  bit          mG [8];
  logic [25:0] mLo [8][2];

  function automatic logic [25:0] lo(input logic [19:0] pfn, input int c, input bit d, input bit v, input bit g);
    return {pfn, 3'(c), d, v, g};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: predict, update model, advance, compare.
  task automatic cycle(input string tag);
    bit eValid;
    logic [2:0] eCode;
    logic [31:0] ePa, eBad;
    logic [7:0] eAsid;
    logic [18:0] eVpn2;
    logic [1:0] eVpn2x;
    bit kern, tinfo;
    int sel;
    logic [20:0] mask;
    logic [25:0] w;
    int half;
    eValid = lkValid; eCode = 0; ePa = 0; eBad = 0; eAsid = 0; eVpn2 = 0; eVpn2x = 0; tinfo = 0;
    kern = ((status & 32'h1000_0006) != 0) || (status[4:3] == 2'b00);
    if (lkVaddr[31:29] == 3'b101) ePa = lkVaddr & 32'h1FFF_FFFF;
    else if (lkVaddr[31:29] == 3'b100) begin
      if (!kern || lkMisaligned) eCode = 1; else ePa = lkVaddr & 32'h1FFF_FFFF;
    end else if (lkMisaligned) eCode = 1;
    else begin
      mask = smallPages ? 21'h1FFFFF : 21'h1FFFFC;
      sel = -1;
      for (int i = 0; i < 8; i++)
        if (sel < 0 && (mLo[i][0][1] || mLo[i][1][1]) &&
            ((lkVaddr[31:11] & mask) == (mVpn[i] & mask)) && (mG[i] || mAsid[i] == lkAsid))
          sel = i;
      half = smallPages ? int'(lkVaddr[10]) : int'(lkVaddr[12]);
      if (sel < 0) begin eCode = lkIsData ? 3'd4 : 3'd2; tinfo = 1; end
      else begin
        w = mLo[sel][half];
        if (!w[1]) begin eCode = lkIsData ? 3'd5 : 3'd3; tinfo = 1; end
        else if (lkIsData && lkIsWrite && !w[2]) begin eCode = 6; tinfo = 1; end
        else ePa = ({12'h000, w[25:6]} << 12) | (lkVaddr & (smallPages ? 32'h3FF : 32'hFFF));
      end
    end
    if (eCode != 0) eBad = lkVaddr;
    if (tinfo) begin eAsid = lkAsid; eVpn2 = lkVaddr[31:13]; eVpn2x = lkVaddr[12:11]; end
    if (wrEn) begin
      mVpn[wrIdx] = wrVpn; mAsid[wrIdx] = wrAsid; mG[wrIdx] = wrLo0[0] & wrLo1[0];
      mLo[wrIdx][0] = wrLo0; mLo[wrIdx][1] = wrLo1;
    end
    @(posedge clk); @(negedge clk);
    if (!eValid) check({tag, " idle"}, 128'(rspValid), 128'(0));
    else check(tag,
      {rspValid, rspCode, rspPaddr, rspBadVaddr, rspAsid, rspVpn2, rspVpn2x, rspCtxVpn2},
      {1'b1, eCode, ePa, eBad, eAsid, eVpn2, eVpn2x, eVpn2});
    wrEn = 0; lkValid = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] a, input bit d, input bit wr, input string tag);
    lkValid = 1; lkVaddr = va; lkAsid = a; lkIsData = d; lkIsWrite = wr;
    cycle(tag);
  endtask

  task automatic put(input int idx, input logic [20:0] vpn, input logic [7:0] a, input logic [25:0] l0, input logic [25:0] l1);
    wrEn = 1; wrIdx = 3'(idx); wrVpn = vpn; wrAsid = a; wrLo0 = l0; wrLo1 = l1;
  endtask

  task automatic readChk(input int idx, input string tag);
    rdIdx = 3'(idx); #1;
    check(tag, {rdLo0, rdLo1},
      {mLo[idx][0][25:1], mG[idx], mLo[idx][1][25:1], mG[idx]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mVpn[i] = 0; mAsid[i] = 0; mG[i] = 0; mLo[i][0] = 0; mLo[i][1] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset response", {rspValid, rspCode, rspPaddr, rspBadVaddr}, '0);
    check("R2 reset entry read", {rdLo0, rdLo1}, '0);
    rstN = 1;
    status = 32'h0;

    // R13: write entry 0 while looking up its page: old content, refill
    put(0, 21'h000800, 8'd5, lo(20'h12345, 3, 1, 1, 0), lo(20'h0ABCD, 2, 0, 1, 0));
    lkValid = 1; lkVaddr = 32'h0040_0010; lkAsid = 5; lkIsData = 0; lkIsWrite = 0;
    cycle("R13 lookup during write");
    readChk(0, "R2 read packing entry0");
    look(32'h0040_0123, 5, 0, 0, "R7 even half instruction hit");
    look(32'h0040_1456, 5, 1, 0, "R4 odd half data read");
    look(32'h0040_1456, 5, 1, 1, "R6 store to clean page modified");
    look(32'h0040_0456, 5, 1, 1, "R6 store to dirty page");
    look(32'h0040_1456, 5, 0, 0, "R6 fetch ignores dirty");
    look(32'h0040_0123, 6, 0, 0, "R3 asid mismatch instr refill");
    look(32'h0040_0123, 6, 1, 0, "R5 data refill");
    look(32'h0040_0123, 5, 0, 0, "R1 back-to-back");
    cycle("R1 no lookup");

    // global entry with invalid even half
    put(1, 21'h000900, 8'd9, lo(20'h00011, 0, 1, 0, 1), lo(20'h00022, 1, 1, 1, 1));
    cycle("R1 idle during write");
    readChk(1, "R2 global flag readback");
    look(32'h0048_0ABC, 3, 0, 0, "R5 instr invalid fields R8");
    look(32'h0048_0ABC, 3, 1, 1, "R5 data invalid");
    look(32'h0048_1ABC, 3, 1, 1, "R3 global match odd half");

    // R12: entry 3 duplicates entry 0's tag
    put(3, 21'h000800, 8'd5, lo(20'h33333, 0, 1, 1, 0), lo(20'h44444, 0, 1, 1, 0));
    cycle("R1 idle during write");
    look(32'h0040_0123, 5, 0, 0, "R12 lowest index wins");
    put(0, 21'h000800, 8'd5, 26'd0, 26'd0);
    cycle("R1 idle during write");
    readChk(0, "R2 cleared entry read");
    look(32'h0040_0123, 5, 0, 0, "R3 empty entry never matches R12");
    look(32'h0040_0923, 5, 0, 0, "R3 low tag bits ignored normal mode");

    // small pages
    smallPages = 1;
    look(32'h0040_0123, 5, 0, 0, "R4 small page even");
    look(32'h0040_0523, 5, 1, 0, "R4 small page odd R7");
    look(32'h0040_0923, 5, 1, 0, "R3 small page full tag refill R8");
    smallPages = 0;

    // unmapped windows and mode decode
    status = 32'h0000_0010;
    look(32'hA000_1234, 1, 1, 0, "R9 uncached window user mode");
    lkMisaligned = 1;
    look(32'hA000_1235, 1, 1, 0, "R9 uncached misaligned");
    lkMisaligned = 0;
    look(32'h8000_ABCD, 1, 1, 0, "R10 cached window user");
    status = 32'h0000_0008;
    look(32'h8000_ABCD, 1, 0, 0, "R11 supervisor not kernel");
    status = 32'h0000_0018;
    look(32'h8000_ABCD, 1, 0, 0, "R11 field 3 not kernel");
    status = 32'h0000_0012;
    look(32'h8000_ABCD, 1, 0, 0, "R11 bit1 gives kernel");
    status = 32'h1000_0010;
    look(32'h8000_ABCD, 1, 0, 0, "R11 bit28 gives kernel");
    status = 32'h0000_0014;
    look(32'h8000_ABCD, 1, 0, 0, "R11 bit2 gives kernel");
    status = 32'h0;
    look(32'h9FFF_FFF0, 1, 1, 1, "R9 cached window kernel");
    lkMisaligned = 1;
    look(32'h8000_0002, 1, 1, 0, "R10 cached window misaligned");
    look(32'h0048_1ABD, 3, 1, 0, "R10 mapped misaligned over hit");
    lkMisaligned = 0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule